// File: doc/BRIEF.md
# I2C Command-Queue Master

This block is a bus master for a two-wire serial bus. Software, or a hardware sequencer, pushes command words into a transmit queue. Each word carries a byte, a direction bit and a stop flag. When the engine is enabled and the first command arrives, it generates the START condition and the address phase by itself, using the 7-bit target address held in a register. It then moves one byte per queued command. Bytes read from the bus are collected in a receive queue, and reads of the data register pop them.

Between queued words the engine decides on its own what the bus needs. A change of direction without an intervening stop produces a repeated START and a fresh address phase. A word with the stop flag ends the transfer with a STOP condition. An empty queue with no stop pending parks the bus with the clock held low until more words arrive. Bit timing comes from a quarter-bit tick divided down from the core clock. The pins are open-drain: the outputs request a low level, and the data line is read back.

Top module: `i2cq_master`

## Requirements
- R1: Register 7 reads 0x44570140. After reset the status register (address 4) reads 0x6, the raw stop bit (address 5, bit 0) reads 0, and the enable status (address 2, bit 0) reads 0.
- R2: A write to address 0 queues a command word. Bits 7:0 are the byte, bit 8 set means read, and bit 9 set means stop after this byte. A write made while CMD_DEPTH words are already queued is dropped.
- R3: When enabled with an idle bus, the first queued word causes a START followed by the address byte, which is the target address in bits 7:1 and that word's read bit in bit 0.
- R4: Write bytes are sent MSB first. For a read word the byte field is ignored and the master leaves SDA released for all eight data bits.
- R5: A word with the stop flag is followed, after its acknowledge bit, by a STOP condition.
- R6: Read bytes are acknowledged (SDA low), except a read word with the stop flag, which is answered with NACK. Each received byte enters the receive queue, and a read of address 0 returns the oldest byte and removes it.
- R7: A word whose direction differs from the current transfer, with no stop flag before it, causes a repeated START and a new address byte carrying the new direction.
- R8: If the queue empties with no stop flag pending, SCL is held low with no START or STOP, and the transfer resumes with the next queued word.
- R9: The raw stop bit (address 5, bit 0) is set when a STOP has been generated. A read of address 6 returns that bit and clears it.
- R10: The enable status (address 2) takes the value of the enable bit (address 1, bit 0) only while the engine is idle. Clearing enable while the bus is parked makes the engine issue a STOP, after which the status drops to 0.
- R11: A write to the target register (address 3, bits 6:0) is ignored while either the enable bit or the enable status is set.
- R12: Status bits are: bit 0 transfer active, bit 1 command queue not full, bit 2 command queue empty, bit 3 receive queue not empty.
- R13: While the engine is idle, neither SCL nor SDA is pulled low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops and clears act on it) |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 10 | Write data |
| reg_rdata | output | 32 | Read data for the addressed register |
| scl_oe | output | 1 | Pull SCL low when 1 |
| sda_oe | output | 1 | Pull SDA low when 1 |
| sda_in | input | 1 | Sensed SDA level |

## Verification
A bench-side slave decodes the wires into START, STOP and byte-with-acknowledge events, and compares them with a sequence derived from the queued words. The sequences cover a write followed by a read, a read word whose byte field is zero, a direction change, a parked bus, a disable while parked and a full queue. An engine that let a read word's byte drive SDA would corrupt the slave's data. An engine that skipped the repeated START would send the read byte in the wrong direction. Acknowledging the final read byte would keep the slave driving and block the STOP. A late or missing STOP on disable would leave the enable status stuck at 1.

// File: rtl/i2cq_pkg.sv
`timescale 1ns/1ps
package i2cq_pkg;
  localparam logic [31:0] IDENT_VALUE = 32'h4457_0140;
  localparam int CMD_W = 10;
  localparam int CMD_RD_BIT = 8;
  localparam int CMD_STOP_BIT = 9;

  localparam logic [2:0] A_DATA   = 3'd0;
  localparam logic [2:0] A_CTRL   = 3'd1;
  localparam logic [2:0] A_ENSTAT = 3'd2;
  localparam logic [2:0] A_TARGET = 3'd3;
  localparam logic [2:0] A_STATUS = 3'd4;
  localparam logic [2:0] A_RAW    = 3'd5;
  localparam logic [2:0] A_CLR    = 3'd6;
  localparam logic [2:0] A_IDENT  = 3'd7;

  typedef enum logic [2:0] {
    EN_IDLE, EN_START, EN_BYTE, EN_ACK, EN_HOLD, EN_STOP
  } eng_state_t;
endpackage

// File: rtl/i2cq_fifo.sv
`timescale 1ns/1ps
module i2cq_fifo #(
  parameter int W = 8,
  parameter int DEPTH = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] wdata,
  input  logic         pop,
  output logic [W-1:0] rdata,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q, wp_d, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          do_push, do_pop;

  assign empty   = (cnt_q == '0);
  assign full    = (cnt_q == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign rdata   = mem[rp_q];

  always_comb begin
    wp_d  = wp_q;
    rp_d  = rp_q;
    cnt_d = cnt_q;
    if (do_push) wp_d = (wp_q == LAST) ? '0 : wp_q + 1'b1;
    if (do_pop)  rp_d = (rp_q == LAST) ? '0 : rp_q + 1'b1;
    if (do_push && !do_pop)      cnt_d = cnt_q + 1'b1;
    else if (do_pop && !do_push) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) mem[wp_q] <= wdata;
  end
endmodule

// File: rtl/i2cq_tick.sv
`timescale 1ns/1ps
module i2cq_tick #(
  parameter int DIV = 8
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;

  assign tick  = (cnt_q == LAST);
  assign cnt_d = tick ? '0 : cnt_q + 1'b1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/i2cq_engine.sv
`timescale 1ns/1ps
module i2cq_engine
  import i2cq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             enable,
  input  logic [6:0]       target,
  input  logic             cmd_ne,
  input  logic [CMD_W-1:0] cmd_word,
  output logic             cmd_pop,
  output logic             rx_push,
  output logic [7:0]       rx_byte,
  output logic             idle,
  output logic             stop_done,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  eng_state_t state_q, state_d;
  logic [1:0] q_q, q_d;
  logic [2:0] bit_q, bit_d;
  logic [7:0] sh_q, sh_d;
  logic       rd_q, rd_d;
  logic       addr_q, addr_d;
  logic       last_q, last_d;
  logic       rs_q, rs_d;
  logic       decide, load;
  logic       rx_phase;

  assign idle     = (state_q == EN_IDLE);
  assign rx_byte  = {sh_q[6:0], sda_in};
  assign rx_phase = rd_q && !addr_q;

  always_comb begin
    state_d   = state_q;
    q_d       = q_q;
    bit_d     = bit_q;
    sh_d      = sh_q;
    rd_d      = rd_q;
    addr_d    = addr_q;
    last_d    = last_q;
    rs_d      = rs_q;
    cmd_pop   = 1'b0;
    rx_push   = 1'b0;
    stop_done = 1'b0;
    decide    = 1'b0;
    load      = 1'b0;
    case (state_q)
      EN_IDLE: begin
        if (enable && cmd_ne) begin
          state_d = EN_START;
          q_d     = 2'd0;
          rs_d    = 1'b0;
        end
      end
      EN_START: begin
        if (tick) begin
          if (q_q == 2'd3) begin
            state_d = EN_BYTE;
            q_d     = 2'd0;
            bit_d   = 3'd7;
            sh_d    = {target, cmd_word[CMD_RD_BIT]};
            rd_d    = cmd_word[CMD_RD_BIT];
            addr_d  = 1'b1;
          end else begin
            q_d = q_q + 2'd1;
          end
        end
      end
      EN_BYTE: begin
        if (tick) begin
          if (q_q == 2'd3) begin
            sh_d = {sh_q[6:0], sda_in};
            q_d  = 2'd0;
            if (bit_q == 3'd0) begin
              state_d = EN_ACK;
              rx_push = rx_phase;
            end else begin
              bit_d = bit_q - 3'd1;
            end
          end else begin
            q_d = q_q + 2'd1;
          end
        end
      end
      EN_ACK: begin
        if (tick) begin
          if (q_q == 2'd3) begin
            q_d = 2'd0;
            if (addr_q)      load = 1'b1;
            else if (last_q) state_d = EN_STOP;
            else             decide = 1'b1;
          end else begin
            q_d = q_q + 2'd1;
          end
        end
      end
      EN_HOLD: begin
        if (cmd_ne) begin
          decide = 1'b1;
        end else if (!enable) begin
          state_d = EN_STOP;
          q_d     = 2'd0;
        end
      end
      EN_STOP: begin
        if (tick) begin
          if (q_q == 2'd3) begin
            state_d   = EN_IDLE;
            q_d       = 2'd0;
            stop_done = 1'b1;
          end else begin
            q_d = q_q + 2'd1;
          end
        end
      end
      default: state_d = EN_IDLE;
    endcase

    if (decide) begin
      if (!cmd_ne) begin
        state_d = EN_HOLD;
      end else if (cmd_word[CMD_RD_BIT] != rd_q) begin
        state_d = EN_START;
        q_d     = 2'd0;
        rs_d    = 1'b1;
      end else begin
        load = 1'b1;
      end
    end

    if (load) begin
      state_d = EN_BYTE;
      q_d     = 2'd0;
      bit_d   = 3'd7;
      sh_d    = cmd_word[7:0];
      last_d  = cmd_word[CMD_STOP_BIT];
      addr_d  = 1'b0;
      cmd_pop = 1'b1;
    end
  end

  always_comb begin
    scl_oe = 1'b0;
    sda_oe = 1'b0;
    case (state_q)
      EN_START: begin
        scl_oe = rs_q && (q_q == 2'd0);
        sda_oe = q_q[1];
      end
      EN_BYTE: begin
        scl_oe = !q_q[1];
        sda_oe = rx_phase ? 1'b0 : !sh_q[7];
      end
      EN_ACK: begin
        scl_oe = !q_q[1];
        sda_oe = rx_phase ? !last_q : 1'b0;
      end
      EN_HOLD: begin
        scl_oe = 1'b1;
      end
      EN_STOP: begin
        scl_oe = (q_q == 2'd0);
        sda_oe = !q_q[1];
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= EN_IDLE;
      q_q     <= 2'd0;
      bit_q   <= 3'd0;
      sh_q    <= 8'd0;
      rd_q    <= 1'b0;
      addr_q  <= 1'b0;
      last_q  <= 1'b0;
      rs_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      q_q     <= q_d;
      bit_q   <= bit_d;
      sh_q    <= sh_d;
      rd_q    <= rd_d;
      addr_q  <= addr_d;
      last_q  <= last_d;
      rs_q    <= rs_d;
    end
  end
endmodule

// File: rtl/i2cq_master.sv
`timescale 1ns/1ps
module i2cq_master
  import i2cq_pkg::*;
#(
  parameter int TICK_DIV  = 8,
  parameter int CMD_DEPTH = 8,
  parameter int RX_DEPTH  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_wr,
  input  logic             reg_rd,
  input  logic [2:0]       reg_addr,
  input  logic [CMD_W-1:0] reg_wdata,
  output logic [31:0]      reg_rdata,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             sda_in
);
  logic             tick;
  logic             en_ctl, en_st, raw_stop;
  logic [6:0]       tgt;
  logic             cmd_push, cmd_pop, cmd_empty, cmd_full, cmd_ne;
  logic [CMD_W-1:0] cmd_word;
  logic             rx_push, rx_pop, rx_empty, rx_full;
  logic [7:0]       rx_byte, rx_head;
  logic             eng_idle, stop_done;
  logic             wr_ctl, wr_tgt, rd_clr;

  assign cmd_push = reg_wr && (reg_addr == A_DATA);
  assign rx_pop   = reg_rd && (reg_addr == A_DATA);
  assign wr_ctl   = reg_wr && (reg_addr == A_CTRL);
  assign wr_tgt   = reg_wr && (reg_addr == A_TARGET) && !en_ctl && !en_st;
  assign rd_clr   = reg_rd && (reg_addr == A_CLR);
  assign cmd_ne   = !cmd_empty;

  i2cq_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  i2cq_fifo #(.W(CMD_W), .DEPTH(CMD_DEPTH)) u_cmdq (
    .clk(clk), .rst_n(rst_n), .push(cmd_push), .wdata(reg_wdata),
    .pop(cmd_pop), .rdata(cmd_word), .empty(cmd_empty), .full(cmd_full)
  );

  i2cq_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(rx_push), .wdata(rx_byte),
    .pop(rx_pop), .rdata(rx_head), .empty(rx_empty), .full(rx_full)
  );

  i2cq_engine u_eng (
    .clk(clk), .rst_n(rst_n), .tick(tick), .enable(en_ctl), .target(tgt),
    .cmd_ne(cmd_ne), .cmd_word(cmd_word), .cmd_pop(cmd_pop),
    .rx_push(rx_push), .rx_byte(rx_byte), .idle(eng_idle),
    .stop_done(stop_done), .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_ctl   <= 1'b0;
      en_st    <= 1'b0;
      tgt      <= 7'd0;
      raw_stop <= 1'b0;
    end else begin
      if (wr_ctl)   en_ctl <= reg_wdata[0];
      if (eng_idle) en_st  <= en_ctl;
      if (wr_tgt)   tgt    <= reg_wdata[6:0];
      if (stop_done)   raw_stop <= 1'b1;
      else if (rd_clr) raw_stop <= 1'b0;
    end
  end

  always_comb begin
    reg_rdata = 32'd0;
    case (reg_addr)
      A_DATA:   reg_rdata = {24'd0, rx_empty ? 8'd0 : rx_head};
      A_CTRL:   reg_rdata = {31'd0, en_ctl};
      A_ENSTAT: reg_rdata = {31'd0, en_st};
      A_TARGET: reg_rdata = {25'd0, tgt};
      A_STATUS: reg_rdata = {28'd0, !rx_empty, cmd_empty, !cmd_full, !eng_idle};
      A_RAW:    reg_rdata = {31'd0, raw_stop};
      A_CLR:    reg_rdata = {31'd0, raw_stop};
      A_IDENT:  reg_rdata = IDENT_VALUE;
      default:  reg_rdata = 32'd0;
    endcase
  end

  logic unused_rx_full;
  assign unused_rx_full = rx_full;
endmodule

// File: rtl/i2cq_master_chk.sv
`timescale 1ns/1ps
module i2cq_master_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       eng_idle,
  input logic       en_ctl,
  input logic       en_st,
  input logic [6:0] tgt,
  input logic       raw_stop,
  input logic       stop_done,
  input logic       scl_oe,
  input logic       sda_oe,
  input logic       cmd_pop,
  input logic       cmd_ne
);
  // R13
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    eng_idle |-> (!scl_oe && !sda_oe));

  // R10
  enstat_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(en_st) |-> $past(eng_idle));

  // R11
  target_lock_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(en_ctl) || $past(en_st)) |-> $stable(tgt));

  // R9
  stop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(raw_stop) |-> $past(stop_done));

  // R2
  pop_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_pop |-> cmd_ne);
endmodule

bind i2cq_master i2cq_master_chk u_chk (
  .clk(clk), .rst_n(rst_n), .eng_idle(eng_idle), .en_ctl(en_ctl),
  .en_st(en_st), .tgt(tgt), .raw_stop(raw_stop), .stop_done(stop_done),
  .scl_oe(scl_oe), .sda_oe(sda_oe), .cmd_pop(cmd_pop), .cmd_ne(cmd_ne)
);

// File: tb/i2cq_master_tb.sv
`timescale 1ns/1ps
module i2cq_master_tb;
  localparam int DEPTH = 4;
  localparam int TGT = 'h2A;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        reg_wr, reg_rd;
  logic [2:0]  reg_addr;
  logic [9:0]  reg_wdata;
  logic [31:0] reg_rdata;
  logic        scl_oe, sda_oe, sda_in;
  logic        slave_low;
  logic        scl_line, sda_line;

  int total = 0, bad = 0;
  bit done = 0;
  int ev_q[$];
  int exp_q[$];
  int mrd = 0;

  always #2.5 clk = ~clk;

  assign scl_line = !scl_oe;
  assign sda_line = !(sda_oe || slave_low);
  assign sda_in   = sda_line;

  i2cq_master #(.TICK_DIV(4), .CMD_DEPTH(DEPTH), .RX_DEPTH(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .scl_oe(scl_oe), .sda_oe(sda_oe), .sda_in(sda_in)
  );

  // behavioural bus slave and event recorder
  logic ps, pd, first, sending, ack_bit;
  logic [7:0] byte_in, tx_sh;
  int bitcnt, rd_cnt;
  always @(negedge clk) begin
    logic cs, cd;
    if (!rst_n) begin
      ps = 1; pd = 1; first = 0; sending = 0; ack_bit = 1;
      byte_in = 0; tx_sh = 0; bitcnt = 0; rd_cnt = 0; slave_low = 0;
    end else begin
      cs = scl_line;
      cd = sda_line;
      if (ps && cs && pd && !cd) begin
        ev_q.push_back(-1); bitcnt = 0; first = 1; sending = 0; slave_low = 0;
      end else if (ps && cs && !pd && cd) begin
        ev_q.push_back(-2); bitcnt = 0; sending = 0; slave_low = 0;
      end else if (!ps && cs) begin
        if (bitcnt < 8) begin
          byte_in = {byte_in[6:0], cd}; bitcnt++;
        end else if (bitcnt == 8) begin
          ev_q.push_back(int'({cd, byte_in}));
          ack_bit = cd;
          if (first) sending = byte_in[0];
          bitcnt = 9;
        end
      end else if (ps && !cs) begin
        if (bitcnt == 8) begin
          slave_low = first || !sending;
        end else if (bitcnt == 9) begin
          bitcnt = 0;
          slave_low = 0;
          if (sending && !ack_bit) begin
            tx_sh = 8'hA0 + 8'(rd_cnt);
            rd_cnt++;
            slave_low = !tx_sh[7];
          end
          first = 0;
        end else if (bitcnt >= 1 && bitcnt <= 7 && sending && !first) begin
          slave_low = !tx_sh[7 - bitcnt];
        end
      end
      ps = cs;
      pd = cd;
    end
  end

  task automatic chk(string req, int act, int exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic reg_write(logic [2:0] a, logic [9:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1;
    @(negedge clk);
    reg_wr = 0;
  endtask

  task automatic reg_read(logic [2:0] a, output logic [31:0] v);
    @(negedge clk);
    reg_addr = a; reg_rd = 1;
    #1 v = reg_rdata;
    @(negedge clk);
    reg_rd = 0;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 20000; i++) begin
      reg_read(3'd4, v);
      if (v[0] == 0 && v[2] == 1) break;
    end
    repeat (4) @(negedge clk);
  endtask

  task automatic exp_s(); exp_q.push_back(-1); endtask
  task automatic exp_p(); exp_q.push_back(-2); endtask
  task automatic exp_b(int b, int nack); exp_q.push_back((nack << 8) | (b & 'hFF)); endtask
  function automatic int next_rd(); int r; r = ('hA0 + mrd) & 'hFF; mrd++; return r; endfunction

  task automatic cmp_events(string req);
    chk({req, " event count"}, ev_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < ev_q.size(); i++)
      chk({req, " bus event"}, ev_q[i], exp_q[i]);
    ev_q.delete();
    exp_q.delete();
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    int b;
    rst_n = 0; reg_wr = 0; reg_rd = 0; reg_addr = 0; reg_wdata = 0;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (2) @(negedge clk);

    // R1 reset state and ident
    reg_read(3'd7, v); chk("R1 ident", v, 32'h44570140);
    reg_read(3'd4, v); chk("R1 R12 reset status", v, 6);
    reg_read(3'd5, v); chk("R1 raw stop", v, 0);
    reg_read(3'd2, v); chk("R1 enable status", v, 0);
    chk("R13 lines released at reset", {scl_oe, sda_oe}, 0);

    // R11 target written while disabled
    reg_write(3'd3, 10'(TGT));
    reg_read(3'd3, v); chk("R11 target write while disabled", v, TGT);

    reg_write(3'd1, 1);
    repeat (3) @(negedge clk);
    reg_read(3'd2, v); chk("R10 enable status follows when idle", v, 1);
    reg_write(3'd3, 10'h11);
    reg_read(3'd3, v); chk("R11 target write ignored while enabled", v, TGT);

    // R3 R4 R5 write transfer
    reg_write(3'd0, 10'h03C);
    reg_write(3'd0, 10'h2C3);
    exp_s(); exp_b(TGT << 1, 0); exp_b('h3C, 0); exp_b('hC3, 0); exp_p();
    wait_idle();
    cmp_events("R3 R4 R5 write");
    chk("R13 lines released after stop", {scl_oe, sda_oe}, 0);

    // R9 stop flag and clear on read
    reg_read(3'd5, v); chk("R9 raw stop set", v, 1);
    reg_read(3'd6, v); chk("R9 clear read returns bit", v, 1);
    reg_read(3'd5, v); chk("R9 raw stop cleared", v, 0);

    // R4 R6 read transfer, byte field ignored on reads
    reg_write(3'd0, 10'h100);
    reg_write(3'd0, 10'h155);
    reg_write(3'd0, 10'h300);
    exp_s(); exp_b((TGT << 1) | 1, 0);
    exp_b(next_rd(), 0); exp_b(next_rd(), 0); exp_b(next_rd(), 1); exp_p();
    wait_idle();
    cmp_events("R4 R6 read");
    reg_read(3'd4, v); chk("R12 rx not empty", v[3], 1);
    for (int i = 0; i < 3; i++) begin
      reg_read(3'd0, v); chk("R6 rx byte", v, 'hA0 + i);
    end
    reg_read(3'd4, v); chk("R6 R12 rx drained", v[3], 0);
    reg_read(3'd6, v);

    // R7 direction change
    reg_write(3'd0, 10'h011);
    reg_write(3'd0, 10'h300);
    exp_s(); exp_b(TGT << 1, 0); exp_b('h11, 0);
    exp_s(); exp_b((TGT << 1) | 1, 0); exp_b(next_rd(), 1); exp_p();
    wait_idle();
    cmp_events("R7 repeated start");
    reg_read(3'd0, v); chk("R7 rx byte after restart", v, 'hA3);

    // R8 parked bus
    reg_write(3'd0, 10'h055);
    repeat (400) @(negedge clk);
    chk("R8 scl held low", scl_oe, 1);
    reg_read(3'd4, v); chk("R8 R12 active while parked", v[0], 1);
    reg_write(3'd0, 10'h266);
    exp_s(); exp_b(TGT << 1, 0); exp_b('h55, 0); exp_b('h66, 0); exp_p();
    wait_idle();
    cmp_events("R8 resume");
    reg_read(3'd6, v);

    // R10 disable while parked
    reg_write(3'd0, 10'h077);
    repeat (400) @(negedge clk);
    reg_write(3'd1, 0);
    reg_read(3'd2, v); chk("R10 status held while busy", v, 1);
    exp_s(); exp_b(TGT << 1, 0); exp_b('h77, 0); exp_p();
    wait_idle();
    cmp_events("R10 stop on disable");
    reg_read(3'd2, v); chk("R10 status cleared when idle", v, 0);
    reg_read(3'd5, v); chk("R9 R10 stop flag after disable", v, 1);
    reg_read(3'd6, v);

    // R2 full command queue while disabled
    reg_write(3'd0, 10'h001);
    reg_write(3'd0, 10'h002);
    reg_write(3'd0, 10'h003);
    reg_write(3'd0, 10'h204);
    reg_read(3'd4, v); chk("R2 R12 queue full status", v, 0);
    reg_write(3'd0, 10'h0EE);
    repeat (50) @(negedge clk);
    chk("R2 no bus activity while disabled", ev_q.size(), 0);
    reg_write(3'd1, 1);
    exp_s(); exp_b(TGT << 1, 0);
    for (int i = 1; i <= 4; i++) exp_b(i, 0);
    exp_p();
    wait_idle();
    cmp_events("R2 full queue, extra word dropped");
    reg_read(3'd4, v); chk("R12 idle status", v, 6);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule